// File: doc/BRIEF.md
# Zero-Cross Gated Volume Controller

This block keeps the attenuation and mute settings of the television audio channel and decides when each new setting reaches the analog path. Attenuation is split into a coarse stage of 8 dB steps and a fine stage of 1 dB steps. A new setting is either applied at once or held pending until the next zero crossing of the audio signal. The crossing is reported by an external comparator, and holding the change until then avoids audible clicks.

Settings arrive as register writes. A volume write carries coarse, fine, mute and the zero-cross enable in one byte. A mute-only write changes just the mute bit and reuses the last zero-cross enable. A flag reports whether a deferred update has been carried out since the last write, so software can give up on a very slow signal and rewrite with gating turned off. A hardware mute input silences the outputs whatever the registers hold.

Top module: `zc_volume_ctrl`

## Requirements
- R1: After reset, coarse_code = 0, fine_code = 0, atten_db = 0, zc_status = 0, nothing is pending, and mute_out = 1.
- R2: In vol_byte, bits 7:5 are the coarse code, bits 4:2 the fine code, bit 1 the mute (1 = muted) and bit 0 the zero-cross enable. A vol_wr with bit 0 = 0 shows all three fields on the outputs from the first rising edge that samples it.
- R3: A write with zero-cross enable = 1 leaves the outputs unchanged until a rising edge on zc_cmp. The setting is then applied at the third rising clock edge after zc_cmp rises: two synchroniser stages, then the apply.
- R4: zc_status goes to 1 in the same cycle as a deferred setting is applied. Any vol_wr or mute_wr clears it from the edge that samples the write.
- R5: Only the most recent pending setting is applied. A new write replaces a setting that is still waiting.
- R6: mute_wr loads mute_bit as the new mute setting and keeps the coarse and fine codes of the last volume write. It is gated by the zero-cross enable of the last volume write.
- R7: hw_mute = 1 drives mute_out to 1 in the same cycle, without a clock edge. It does not change coarse_code, fine_code or zc_status.
- R8: One comparator rising edge applies at most once. A comparator held high or a falling edge does not apply a setting written later.
- R9: atten_db equals 8 × coarse_code + fine_code, ranging from 0 to 63.
- R10: When vol_wr and mute_wr occur in the same cycle, the volume write wins and mute_bit is ignored.
- R11: When a write arrives in the same cycle as a crossing, the write wins. Its setting waits for the next crossing, and the older pending setting is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vol_wr | input | 1 | Volume write strobe, one cycle |
| vol_byte | input | 8 | Volume control byte |
| mute_wr | input | 1 | Mute-only write strobe |
| mute_bit | input | 1 | Mute value for mute_wr |
| zc_cmp | input | 1 | Asynchronous zero-cross comparator output |
| hw_mute | input | 1 | Hardware mute, active high |
| coarse_code | output | 3 | Applied coarse attenuation code |
| fine_code | output | 3 | Applied fine attenuation code |
| atten_db | output | 6 | Applied total attenuation in dB |
| mute_out | output | 1 | Mute control to the output buffers |
| zc_status | output | 1 | A deferred update has been applied |

## Verification
An immediate write is due on the first rising edge that samples the strobe. A deferred setting is due on the third rising edge after the comparator rises. hw_mute acts on mute_out with no clock edge at all. The bench drives every input on a falling edge and reads the outputs on a later falling edge. For deferred updates it reads once at the second falling edge after the comparator rise, where the old value must remain, and once at the third, where the new value must appear.

// File: rtl/zc_vol_pkg.sv
// Package: shared widths, field positions and the applied-setting record
// for the zero-cross gated volume controller.
package zc_vol_pkg;
    localparam int COARSE_W = 3;
    localparam int FINE_W   = 3;
    localparam int CTRL_W   = COARSE_W + FINE_W + 2;
    localparam int DB_W     = COARSE_W + FINE_W;
    // Field positions inside the volume control byte
    localparam int ZCEN_BIT = 0;
    localparam int MUTE_BIT = 1;
    localparam int FINE_LSB = 2;
    localparam int CRS_LSB  = FINE_LSB + FINE_W;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic                mute;
    } vol_set_t;

    localparam vol_set_t VOL_RESET = '{coarse: '0, fine: '0, mute: 1'b1};
endpackage

// File: rtl/zc_edge_sync.sv
// Module: zc_edge_sync
// Synchronises an asynchronous comparator output through STAGES flops
// and emits a one-cycle pulse per detected edge.
// Assumes: STAGES >= 2; the input stays stable for more than one clock
// between transitions.
module zc_edge_sync #(
    parameter int STAGES     = 2,
    parameter bit BOTH_EDGES = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the comparator level through the synchroniser and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    generate
        if (BOTH_EDGES) begin : g_both
            // Either transition counts as a crossing
            always_comb pulse = chain_q[STAGES-1] ^ prev_q;
        end else begin : g_rise
            // Only the rising transition counts as a crossing
            always_comb pulse = chain_q[STAGES-1] & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/zc_vol_sequencer.sv
// Module: zc_vol_sequencer
// Holds the target setting, the pending flag and the applied setting.
// A write either applies at once or waits for the next crossing pulse.
// Assumes: zc_pulse is already synchronous and one cycle long.
module zc_vol_sequencer
    import zc_vol_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vol_wr,
    input  logic [CTRL_W-1:0] vol_byte,
    input  logic              mute_wr,
    input  logic              mute_bit,
    input  logic              zc_pulse,
    output vol_set_t          applied,
    output logic              pending,
    output logic              zc_status
);
    vol_set_t tgt_q, tgt_nxt;
    logic     zcen_q, zcen_nxt;
    logic     any_wr;

    // Form the new target from whichever write is present (volume write wins)
    always_comb begin
        tgt_nxt  = tgt_q;
        zcen_nxt = zcen_q;
        any_wr   = vol_wr | mute_wr;
        if (vol_wr) begin
            tgt_nxt.coarse = vol_byte[CRS_LSB +: COARSE_W];
            tgt_nxt.fine   = vol_byte[FINE_LSB +: FINE_W];
            tgt_nxt.mute   = vol_byte[MUTE_BIT];
            zcen_nxt       = vol_byte[ZCEN_BIT];
        end else if (mute_wr) begin
            tgt_nxt.mute = mute_bit;
        end
    end

    // Register the target, then apply it at once, on a crossing, or hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q     <= VOL_RESET;
            zcen_q    <= 1'b0;
            applied   <= VOL_RESET;
            pending   <= 1'b0;
            zc_status <= 1'b0;
        end else begin
            tgt_q  <= tgt_nxt;
            zcen_q <= zcen_nxt;
            if (any_wr) begin
                zc_status <= 1'b0;
                if (zcen_nxt) begin
                    pending <= 1'b1;
                end else begin
                    applied <= tgt_nxt;
                    pending <= 1'b0;
                end
            end else if (zc_pulse && pending) begin
                applied   <= tgt_q;
                pending   <= 1'b0;
                zc_status <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/zc_volume_ctrl.sv
// Module: zc_volume_ctrl (top)
// Zero-cross gated volume and mute controller for the television audio
// channel. It combines the synchroniser, the sequencer and the hardware mute.
// Assumes: writes are one-cycle strobes in the clk domain; zc_cmp is async.
module zc_volume_ctrl
    import zc_vol_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit BOTH_EDGES  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vol_wr,
    input  logic [CTRL_W-1:0]   vol_byte,
    input  logic                mute_wr,
    input  logic                mute_bit,
    input  logic                zc_cmp,
    input  logic                hw_mute,
    output logic [COARSE_W-1:0] coarse_code,
    output logic [FINE_W-1:0]   fine_code,
    output logic [DB_W-1:0]     atten_db,
    output logic                mute_out,
    output logic                zc_status
);
    localparam int STEP_SHIFT = FINE_W;

    logic     zc_pulse_w;
    logic     pend_w;
    vol_set_t applied_w;

    zc_edge_sync #(.STAGES(SYNC_STAGES), .BOTH_EDGES(BOTH_EDGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (zc_cmp),
        .pulse    (zc_pulse_w)
    );

    zc_vol_sequencer seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .vol_wr    (vol_wr),
        .vol_byte  (vol_byte),
        .mute_wr   (mute_wr),
        .mute_bit  (mute_bit),
        .zc_pulse  (zc_pulse_w),
        .applied   (applied_w),
        .pending   (pend_w),
        .zc_status (zc_status)
    );

    // Drive the output codes, the total dB and the combined mute
    always_comb begin
        coarse_code = applied_w.coarse;
        fine_code   = applied_w.fine;
        atten_db    = (DB_W'(applied_w.coarse) << STEP_SHIFT) + DB_W'(applied_w.fine);
        mute_out    = applied_w.mute | hw_mute;
    end
endmodule

// File: rtl/zc_volume_ctrl_chk.sv
// Module: zc_volume_ctrl_chk
// Assertion checker bound into zc_volume_ctrl. It observes ports and the
// internal pending and crossing-pulse nets.
module zc_volume_ctrl_chk
    import zc_vol_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                vol_wr,
    input logic [CTRL_W-1:0]   vol_byte,
    input logic                mute_wr,
    input logic                hw_mute,
    input logic [COARSE_W-1:0] coarse_code,
    input logic [FINE_W-1:0]   fine_code,
    input logic                mute_out,
    input logic                zc_status,
    input logic                pending,
    input logic                zc_pulse
);
    // R2: an immediate volume write shows its fields one edge later
    a_r2_immediate_apply: assert property (@(posedge clk) disable iff (!rst_n)
        vol_wr && !vol_byte[ZCEN_BIT] |=>
            coarse_code == $past(vol_byte[CRS_LSB +: COARSE_W]) &&
            fine_code == $past(vol_byte[FINE_LSB +: FINE_W]));

    // R3: while waiting with no crossing and no write, the codes hold
    a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !zc_pulse && !vol_wr && !mute_wr |=>
            $stable(coarse_code) && $stable(fine_code));

    // R4: a crossing that applies a pending setting raises the status
    a_r4_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        pending && zc_pulse && !vol_wr && !mute_wr |=> zc_status);

    // R4: any write clears the status
    a_r4_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        vol_wr || mute_wr |=> !zc_status);

    // R7: hardware mute always silences the output
    a_r7_hw_mute: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mute |-> mute_out);

    // R8: a crossing pulse never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        zc_pulse |=> !zc_pulse);
endmodule

bind zc_volume_ctrl zc_volume_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vol_wr      (vol_wr),
    .vol_byte    (vol_byte),
    .mute_wr     (mute_wr),
    .hw_mute     (hw_mute),
    .coarse_code (coarse_code),
    .fine_code   (fine_code),
    .mute_out    (mute_out),
    .zc_status   (zc_status),
    .pending     (pend_w),
    .zc_pulse    (zc_pulse_w)
);

// File: tb/zc_volume_ctrl_tb_top.sv
// Bench for zc_volume_ctrl: a table walk of immediate writes, then
// directed tests for deferred, mute-only, hardware-mute and collision cases.
module zc_volume_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vol_wr = 1'b0;
    logic [7:0] vol_byte = 8'h00;
    logic       mute_wr = 1'b0;
    logic       mute_bit = 1'b0;
    logic       zc_cmp = 1'b0;
    logic       hw_mute = 1'b0;
    logic [2:0] coarse_code;
    logic [2:0] fine_code;
    logic [5:0] atten_db;
    logic       mute_out;
    logic       zc_status;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    zc_volume_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .vol_wr(vol_wr), .vol_byte(vol_byte),
        .mute_wr(mute_wr), .mute_bit(mute_bit), .zc_cmp(zc_cmp),
        .hw_mute(hw_mute), .coarse_code(coarse_code), .fine_code(fine_code),
        .atten_db(atten_db), .mute_out(mute_out), .zc_status(zc_status)
    );

    // Entry: {byte[7:0], coarse[2:0], fine[2:0], mute, db[5:0]}
    localparam logic [20:0] VEC [6] = '{
        {8'b111_111_0_0, 3'd7, 3'd7, 1'b0, 6'd63},
        {8'b000_000_1_0, 3'd0, 3'd0, 1'b1, 6'd0},
        {8'b101_010_0_0, 3'd5, 3'd2, 1'b0, 6'd42},
        {8'b010_101_1_0, 3'd2, 3'd5, 1'b1, 6'd21},
        {8'b001_000_0_0, 3'd1, 3'd0, 1'b0, 6'd8},
        {8'b000_001_0_0, 3'd0, 3'd1, 1'b0, 6'd1}
    };

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_set(input string req, input int c, input int f, input int m);
        check({req, " coarse"}, coarse_code, c);
        check({req, " fine"}, fine_code, f);
        check({req, " mute"}, mute_out, m);
    endtask

    task automatic write_vol(input logic [7:0] b);
        @(negedge clk); vol_byte = b; vol_wr = 1'b1;
        @(negedge clk); vol_wr = 1'b0;
    endtask

    task automatic write_mute(input logic m);
        @(negedge clk); mute_bit = m; mute_wr = 1'b1;
        @(negedge clk); mute_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got %0d expected < 100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check_set("R1 reset", 0, 0, 1);
        check("R1 status", zc_status, 0);
        check("R1 atten_db", atten_db, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(1);

        // R2/R9: table of immediate writes
        for (int k = 0; k < 6; k++) begin
            write_vol(VEC[k][20:13]);
            check_set("R2 table", int'(VEC[k][12:10]), int'(VEC[k][9:7]), int'(VEC[k][6]));
            check("R9 atten_db", atten_db, int'(VEC[k][5:0]));
        end

        // R3: deferred write waits for the crossing (state now 0,1,unmuted)
        write_vol(8'b011_100_1_1);
        check_set("R3 held", 0, 1, 0);
        check("R4 status after write", zc_status, 0);
        idle(5);
        check_set("R3 still held", 0, 1, 0);
        @(negedge clk); zc_cmp = 1'b1;
        idle(2);
        check_set("R3 not yet at 2nd edge", 0, 1, 0);
        idle(1);
        check_set("R3 applied at 3rd edge", 3, 4, 1);
        check("R4 status set", zc_status, 1);

        // R8: comparator held high does not apply a later write
        write_vol(8'b100_000_0_1);
        check("R4 status cleared", zc_status, 0);
        idle(6);
        check_set("R8 held high no apply", 3, 4, 1);
        @(negedge clk); zc_cmp = 1'b0;
        idle(4);
        check_set("R8 falling edge no apply", 3, 4, 1);
        @(negedge clk); zc_cmp = 1'b1;
        idle(3);
        check_set("R8 next rise applies", 4, 0, 0);
        @(negedge clk); zc_cmp = 1'b0;
        idle(3);

        // R5: the latest pending write wins
        write_vol(8'b110_000_0_1);
        write_vol(8'b001_001_0_1);
        @(negedge clk); zc_cmp = 1'b1;
        idle(3);
        check_set("R5 latest wins", 1, 1, 0);
        @(negedge clk); zc_cmp = 1'b0;
        idle(3);

        // R6: mute-only write, gated by the last enable (1)
        write_mute(1'b1);
        check_set("R6 mute pending", 1, 1, 0);
        @(negedge clk); zc_cmp = 1'b1;
        idle(3);
        check_set("R6 mute applied, codes kept", 1, 1, 1);
        @(negedge clk); zc_cmp = 1'b0;
        idle(3);
        write_vol(8'b010_010_0_0);
        check_set("R6 immediate vol", 2, 2, 0);
        write_mute(1'b1);
        check_set("R6 immediate mute-only", 2, 2, 1);
        write_mute(1'b0);
        check_set("R6 immediate unmute", 2, 2, 0);

        // R7: hardware mute acts with no clock edge
        @(negedge clk); hw_mute = 1'b1;
        #1;
        check("R7 hw mute", mute_out, 1);
        check("R7 coarse kept", coarse_code, 2);
        check("R7 status kept", zc_status, 0);
        @(negedge clk); hw_mute = 1'b0;
        #1;
        check("R7 hw mute released", mute_out, 0);

        // R10: simultaneous writes, the volume write wins
        @(negedge clk); vol_byte = 8'b011_011_0_0; vol_wr = 1'b1; mute_bit = 1'b1; mute_wr = 1'b1;
        @(negedge clk); vol_wr = 1'b0; mute_wr = 1'b0;
        check_set("R10 volume write wins", 3, 3, 0);

        // R11: a write in the crossing cycle waits for the next crossing
        write_vol(8'b100_100_0_1);
        @(negedge clk); zc_cmp = 1'b1;
        @(negedge clk);
        @(negedge clk); vol_byte = 8'b101_101_0_1; vol_wr = 1'b1;
        @(negedge clk); vol_wr = 1'b0;
        check_set("R11 write beats crossing", 3, 3, 0);
        check("R11 status", zc_status, 0);
        zc_cmp = 1'b0;
        idle(3);
        @(negedge clk); zc_cmp = 1'b1;
        idle(3);
        check_set("R11 next crossing applies", 5, 5, 0);
        check("R11 status set", zc_status, 1);

        finish_run();
    end
endmodule